// File: doc/BRIEF.md
# Flash lock bit protection controller

This block decides whether program and verify requests coming from a parallel programming interface may reach the on-chip program flash. It holds two one-way lock bits, `lock1` and `lock2`. A lock bit can move from unprogrammed to programmed, but it cannot move back. The only way to return both bits to unprogrammed is a full chip erase, and that erase clears the flash array at the same time.

The two bits combine into three graded protection modes:

- **Mode 1 (open):** no protection; program and verify are both granted.
- **Mode 2 (program locked):** `lock1` is programmed; program requests are refused, verify is still granted.
- **Mode 3 (fully locked):** program and verify are both refused. This mode applies when both bits are programmed, and also for the partial combination with only `lock2` programmed, so that a partial state never weakens protection.

The lock bits sit on their own power-on reset `pwr_ni`. The functional reset `rst_ni` does not touch them, so they survive it. Any request that is refused sets a sticky error flag. This block does not model the flash array, the high-voltage timing or the pin protocol.

Top module: `flash_lock_ctrl`

## Requirements
- R1: After power-on reset (`pwr_ni` low), both lock bits are unprogrammed and `mode_o` reads 1. `err_o` and `array_erased_o` are 0 once the functional reset `rst_ni` has also been applied.
- R2: In mode 1 (`mode_o`=1), `prog_en_o` equals `prog_req_i` and `verify_en_o` equals `verify_req_i` in the same cycle. The grants are never high without a request.
- R3: In mode 2 (`lock1` programmed, `lock2` not; `mode_o`=2), `prog_en_o` stays 0 and `verify_en_o` equals `verify_req_i`.
- R4: In mode 3 (`mode_o`=3), both `prog_en_o` and `verify_en_o` stay 0 whatever the requests.
- R5: With `lock2` programmed and `lock1` unprogrammed, `mode_o` reads 3. The code 0 never appears on `mode_o`.
- R6: A high `lock1_prog_i` or `lock2_prog_i` in one cycle programs that bit from the next cycle on. Strobing a bit that is already programmed changes nothing. No input other than chip erase returns a bit to unprogrammed.
- R7: A high `chip_erase_i` clears both lock bits from the next cycle (`mode_o`=1). This holds even when a lock program strobe arrives in the same cycle.
- R8: In the cycle after `chip_erase_i` rises, `array_erased_o` is high for exactly one cycle. Holding `chip_erase_i` high for further cycles gives no further pulse.
- R9: A refused request (program request while `mode_o` is not 1, or verify request while `mode_o` is 3) sets `err_o` from the next cycle. `err_o` stays set until `err_clr_i` is high in a cycle with no refused request; a refusal in the same cycle as the clear keeps `err_o` set.
- R10: A low `rst_ni` clears `err_o` and `array_erased_o` at once and leaves both lock bits, and so `mode_o`, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Functional reset, active low, asynchronous |
| pwr_ni | input | 1 | Power-on reset for the lock bits, active low, asynchronous |
| lock1_prog_i | input | 1 | Program strobe for lock bit 1 |
| lock2_prog_i | input | 1 | Program strobe for lock bit 2 |
| chip_erase_i | input | 1 | Chip erase command |
| prog_req_i | input | 1 | Flash program request |
| verify_req_i | input | 1 | Flash verify request |
| err_clr_i | input | 1 | Read-clear strobe for the error flag |
| prog_en_o | output | 1 | Program grant |
| verify_en_o | output | 1 | Verify grant |
| mode_o | output | 2 | Protection mode code (1, 2 or 3) |
| err_o | output | 1 | Sticky refused-request flag |
| array_erased_o | output | 1 | One-cycle array erase pulse |

## Verification
The block has no sizing parameters, so the bench builds it as it stands. Every lock state is reachable in a few cycles: all four bit combinations, including the partial `lock2`-only state. Directed steps cover the following collisions:

- an erase arriving together with a lock program strobe;
- a clear arriving together with a refusal;
- a held erase;
- a functional reset while locked.

A long run of sparse random strobes then lets the reference model compare grants, mode, error flag and erase pulse against the design on every cycle.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;
  localparam int unsigned MODE_W = 2;
  typedef enum logic [MODE_W-1:0] {
    MODE_OPEN      = 2'd1,
    MODE_PROG_LOCK = 2'd2,
    MODE_FULL_LOCK = 2'd3
  } prot_mode_e;
endpackage

// File: rtl/lock_store.sv
module lock_store (
  input  logic clk_i,
  input  logic pwr_ni,
  input  logic set1_i,
  input  logic set2_i,
  input  logic erase_i,
  output logic lb1_o,
  output logic lb2_o
);
  logic lb1_q, lb2_q;

  // one-way bits; only erase clears, erase wins over set
  always_ff @(posedge clk_i or negedge pwr_ni) begin
    if (!pwr_ni) begin
      lb1_q <= 1'b0;
      lb2_q <= 1'b0;
    end else if (erase_i) begin
      lb1_q <= 1'b0;
      lb2_q <= 1'b0;
    end else begin
      lb1_q <= lb1_q | set1_i;
      lb2_q <= lb2_q | set2_i;
    end
  end

  assign lb1_o = lb1_q;
  assign lb2_o = lb2_q;

  // R6
  lb1_one_way_chk: assert property (@(posedge clk_i) disable iff (!pwr_ni)
    $fell(lb1_q) |-> $past(erase_i));
  // R6
  lb2_one_way_chk: assert property (@(posedge clk_i) disable iff (!pwr_ni)
    $fell(lb2_q) |-> $past(erase_i));
  // R7
  erase_clears_chk: assert property (@(posedge clk_i) disable iff (!pwr_ni)
    erase_i |=> (!lb1_q && !lb2_q));
endmodule

// File: rtl/lock_decode.sv
module lock_decode
  import flash_lock_pkg::*;
(
  input  logic       lb1_i,
  input  logic       lb2_i,
  input  logic       prog_req_i,
  input  logic       verify_req_i,
  output prot_mode_e mode_o,
  output logic       prog_en_o,
  output logic       verify_en_o,
  output logic       refused_o
);
  always_comb begin
    unique case ({lb1_i, lb2_i})
      2'b00:   mode_o = MODE_OPEN;
      2'b10:   mode_o = MODE_PROG_LOCK;
      default: mode_o = MODE_FULL_LOCK; // partial lb2-only folds to strictest
    endcase
  end

  assign prog_en_o   = prog_req_i && (mode_o == MODE_OPEN);
  assign verify_en_o = verify_req_i && (mode_o != MODE_FULL_LOCK);
  assign refused_o   = (prog_req_i && !prog_en_o) || (verify_req_i && !verify_en_o);

  // R5
  always_comb mode_nonzero_chk: assert (mode_o != 2'd0);
endmodule

// File: rtl/lock_err.sv
module lock_err (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic err_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_q <= 1'b0;
    else if (set_i)  err_q <= 1'b1;
    else if (clr_i)  err_q <= 1'b0;
  end

  assign err_o = err_q;

  // R9
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> err_q);
  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clr_i) |=> err_q);
endmodule

// File: rtl/erase_pulse.sv
module erase_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic erase_i,
  output logic pulse_o
);
  logic prev_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= erase_i;
      pulse_q <= erase_i && !prev_q;
    end
  end

  assign pulse_o = pulse_q;

  // R8
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);
endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
  import flash_lock_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_ni,
  input  logic              lock1_prog_i,
  input  logic              lock2_prog_i,
  input  logic              chip_erase_i,
  input  logic              prog_req_i,
  input  logic              verify_req_i,
  input  logic              err_clr_i,
  output logic              prog_en_o,
  output logic              verify_en_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              err_o,
  output logic              array_erased_o
);
  logic       lb1, lb2, refused;
  prot_mode_e mode;

  lock_store u_store (
    .clk_i   (clk_i),
    .pwr_ni  (pwr_ni),
    .set1_i  (lock1_prog_i),
    .set2_i  (lock2_prog_i),
    .erase_i (chip_erase_i),
    .lb1_o   (lb1),
    .lb2_o   (lb2)
  );

  lock_decode u_decode (
    .lb1_i        (lb1),
    .lb2_i        (lb2),
    .prog_req_i   (prog_req_i),
    .verify_req_i (verify_req_i),
    .mode_o       (mode),
    .prog_en_o    (prog_en_o),
    .verify_en_o  (verify_en_o),
    .refused_o    (refused)
  );

  lock_err u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (refused),
    .clr_i  (err_clr_i),
    .err_o  (err_o)
  );

  erase_pulse u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .erase_i (chip_erase_i),
    .pulse_o (array_erased_o)
  );

  assign mode_o = mode;

  // R3
  prog_gate_chk: assert property (@(posedge clk_i) disable iff (!pwr_ni)
    prog_en_o |-> (mode_o == MODE_OPEN));
  // R4
  verify_gate_chk: assert property (@(posedge clk_i) disable iff (!pwr_ni)
    verify_en_o |-> (mode_o != MODE_FULL_LOCK));
  // R10
  rst_keeps_mode_chk: assert property (@(posedge clk_i) disable iff (!pwr_ni)
    (!rst_ni && !chip_erase_i && !lock1_prog_i && !lock2_prog_i) |=> $stable(mode_o));
endmodule

// File: tb/flash_lock_ctrl_tb.sv
module flash_lock_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0, pwr_n = 1'b0;
  logic l1 = 0, l2 = 0, ce = 0, pr = 0, vr = 0, clr = 0;
  logic prog_en, verify_en, err, arr;
  logic [1:0] mode;

  int vectors = 0, errors = 0;
  bit m1 = 0, m2 = 0, m_err = 0, m_arr = 0, m_prev = 0;

  always #5 clk = ~clk;

  flash_lock_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_ni(pwr_n),
    .lock1_prog_i(l1), .lock2_prog_i(l2), .chip_erase_i(ce),
    .prog_req_i(pr), .verify_req_i(vr), .err_clr_i(clr),
    .prog_en_o(prog_en), .verify_en_o(verify_en), .mode_o(mode),
    .err_o(err), .array_erased_o(arr)
  );

  function automatic logic [1:0] ref_mode(bit a, bit b);
    if (!a && !b) return 2'd1;
    if (a && !b)  return 2'd2;
    return 2'd3;
  endfunction

  task automatic cmp(string tag, string what, logic [1:0] act, logic [1:0] exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare before posedge, advance model at posedge
  task automatic step(bit r, bit a, bit b, bit e, bit p, bit v, bit c, string tag);
    logic [1:0] md;
    bit gp, gv;
    @(negedge clk);
    rst_n = r; l1 = a; l2 = b; ce = e; pr = p; vr = v; clr = c;
    if (!r) begin m_err = 0; m_arr = 0; m_prev = 0; end
    #1;
    md = ref_mode(m1, m2);
    gp = p && (md == 2'd1);
    gv = v && (md != 2'd3);
    vectors++;
    cmp({tag, " R5 R6 R7"}, "mode_o", mode, md);
    cmp({tag, " R2 R3 R4"}, "prog_en_o", {1'b0, prog_en}, {1'b0, gp});
    cmp({tag, " R2 R3 R4"}, "verify_en_o", {1'b0, verify_en}, {1'b0, gv});
    cmp({tag, " R9 R10"}, "err_o", {1'b0, err}, {1'b0, m_err});
    cmp({tag, " R8 R10"}, "array_erased_o", {1'b0, arr}, {1'b0, m_arr});
    @(posedge clk);
    if (e) begin m1 = 0; m2 = 0; end
    else begin m1 = m1 | a; m2 = m2 | b; end
    if (r) begin
      if ((p && !gp) || (v && !gv)) m_err = 1;
      else if (c) m_err = 0;
      m_arr = e && !m_prev;
      m_prev = e;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    pwr_n = 1'b1;
    // R1 reset state
    step(0,0,0,0,0,0,0,"R1");
    step(1,0,0,0,0,0,0,"R1");
    // R2 open mode grants
    step(1,0,0,0,1,0,0,"R2");
    step(1,0,0,0,0,1,0,"R2");
    step(1,0,0,0,1,1,0,"R2");
    // R6 program lock1 -> mode 2
    step(1,1,0,0,0,0,0,"R6");
    step(1,0,0,0,0,1,0,"R3");
    step(1,0,0,0,1,0,0,"R3 R9");
    step(1,0,0,0,0,0,0,"R9");
    step(1,0,0,0,0,0,1,"R9");
    step(1,0,0,0,0,0,0,"R9");
    step(1,0,0,0,1,0,1,"R9");  // refusal beats clear
    step(1,0,0,0,0,0,0,"R9");
    step(1,1,0,0,0,0,0,"R6");  // already programmed
    // R10 functional reset keeps lock bits
    step(0,0,0,0,0,0,0,"R10");
    step(1,0,0,0,0,1,0,"R10");
    // R7 erase wins over lock program, held for R8
    step(1,0,1,1,0,0,0,"R7 R8");
    step(1,0,0,1,0,0,0,"R8");
    step(1,0,0,1,0,0,0,"R8");
    step(1,0,0,0,1,1,0,"R7");
    // R5 lock2-only is fully locked
    step(1,0,1,0,0,0,0,"R5");
    step(1,0,0,0,1,1,0,"R5 R4");
    step(1,1,0,0,0,1,0,"R4");
    step(1,0,0,0,1,1,0,"R4");
    step(1,0,0,1,0,0,1,"R7");
    step(1,0,0,0,0,0,0,"R8");
    for (int i = 0; i < 2000; i++) begin
      int x;
      x = $urandom_range(0, 99);
      step(($urandom_range(0, 99) != 0),
           (x == 1), (x == 2), (x < 1),
           $urandom_range(0, 1), $urandom_range(0, 1),
           ($urandom_range(0, 3) == 0), "rand");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule